// File: doc/BRIEF.md
# Pixel Component Remap Unit

This block rebuilds every destination pixel from one source pixel. Each of the four destination components has its own three-bit selector. A selector can take any one of the four source components, or one of two constant registers. It can also mark the component as not written. When a component is not written, its byte write-enables are cleared, so a downstream memory keeps the data that is already stored there.

The component width (1 to 4 bytes), the number of source components and the number of destination components all come from one control word. Each of these three fields is stored as its value minus one. Pixels are packed with no gaps: component k takes the bytes starting at byte k times the component size. Source pixels arrive on a valid/ready stream. Destination pixels leave through a single register stage, together with a per-byte write-enable mask and an error flag. Address generation and memory access sit outside the block.

Top module: `pixel_remap`

## Requirements
- R1: Selector codes 0, 1, 2 and 3 copy source component X, Y, Z or W into the destination component. Source component k is read from source bytes k*size up to k*size+size-1.
- R2: Selector code 4 writes the low size bytes of `const_a`. Code 5 writes the low size bytes of `const_b`.
- R3: Selector code 6 clears the write-enables of that component's bytes. The data on those bytes is zero. Across the whole output, every byte whose enable is low carries zero.
- R4: Code 7 is reserved. A code from 0 to 3 that names a source component at or above the source count is out of range. Either case sets the component's data to zero with its enables set, and raises `out_err` for that pixel.
- R5: Destination components at index dst_count and above produce no bytes: enables low, data zero. Their selectors never raise `out_err`.
- R6: The component size is taken from control bits [17:16] as size minus one. Destination component j occupies output bytes j*size up to j*size+size-1, and all bytes past dst_count*size are disabled.
- R7: A pixel accepted on a rising edge (`in_valid` and `in_ready` both high) appears on the outputs after that same edge, with `out_valid` high. `in_ready` is high whenever the output register is empty or being drained.
- R8: While `out_valid` is high and `out_ready` is low, the output pixel, mask and error flag are held, and `in_ready` is low.
- R9: While `rst` is high, `out_valid` is low on the next edge and `in_ready` is high.
- R10: Control word layout: selectors for destination X, Y, Z and W sit at bits [2:0], [6:4], [10:8] and [14:12]. The source count minus one sits at [21:20], and the destination count minus one at [25:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| const_a | input | 32 | First constant register |
| const_b | input | 32 | Second constant register |
| remap_ctrl | input | 32 | Remap control word (selectors, size, counts) |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Block can take a source pixel |
| in_pixel | input | 128 | Packed source pixel, byte 0 in bits [7:0] |
| out_valid | output | 1 | Destination pixel valid |
| out_ready | input | 1 | Consumer takes the destination pixel |
| out_pixel | output | 128 | Packed destination pixel |
| out_be | output | 16 | Per-byte write-enable of the destination pixel |
| out_err | output | 1 | Some active selector was reserved or out of range |

## Verification
The assertions assume that the configuration inputs hold steady during any cycle in which a pixel is accepted. They also assume the consumer keeps to the handshake: the hold property checks stability only while `out_ready` is low. The stimulus changes the constants and the control word only on falling edges, and only together with a new pixel. `out_ready` is driven only on falling edges, so every accept and drain falls on a clean rising edge.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_SX   = 3'd0,
    SEL_SY   = 3'd1,
    SEL_SZ   = 3'd2,
    SEL_SW   = 3'd3,
    SEL_KA   = 3'd4,
    SEL_KB   = 3'd5,
    SEL_SKIP = 3'd6,
    SEL_RSVD = 3'd7
  } sel_e;

  typedef struct packed {
    logic [3:0][SEL_W-1:0] sel;
    logic [CNT_W-1:0]      size_m1;
    logic [CNT_W-1:0]      src_m1;
    logic [CNT_W-1:0]      dst_m1;
  } remap_cfg_t;
endpackage

// File: rtl/remap_cfg_decode.sv
module remap_cfg_decode
  import remap_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int NUM_COMP = 4,
  parameter int SEL_STEP = 4
) (
  input  logic [CTRL_W-1:0] ctrl,
  output remap_cfg_t        cfg
);
  localparam int SIZE_LSB = 16;
  localparam int SRC_LSB  = 20;
  localparam int DST_LSB  = 24;

  for (genvar i = 0; i < NUM_COMP; i++) begin : g_sel
    assign cfg.sel[i] = ctrl[i*SEL_STEP +: SEL_W];
  end
  assign cfg.size_m1 = ctrl[SIZE_LSB +: CNT_W];
  assign cfg.src_m1  = ctrl[SRC_LSB  +: CNT_W];
  assign cfg.dst_m1  = ctrl[DST_LSB  +: CNT_W];
endmodule

// File: rtl/remap_lane.sv
module remap_lane
  import remap_pkg::*;
#(
  parameter int COMP_BYTES = 4,
  parameter int NUM_COMP   = 4
) (
  input  logic [SEL_W-1:0]                   sel,
  input  logic [CNT_W-1:0]                   size_m1,
  input  logic [CNT_W-1:0]                   src_m1,
  input  logic                               active,
  input  logic [COMP_BYTES*NUM_COMP*8-1:0]   src_px,
  input  logic [COMP_BYTES*8-1:0]            ka,
  input  logic [COMP_BYTES*8-1:0]            kb,
  output logic [COMP_BYTES*8-1:0]            comp,
  output logic                               write,
  output logic                               err
);
  localparam int COMP_W    = COMP_BYTES * 8;
  localparam int PIX_BYTES = COMP_BYTES * NUM_COMP;
  localparam int IDX_W     = $clog2(PIX_BYTES);

  logic [PIX_BYTES-1:0][7:0]       px_b;
  logic [NUM_COMP-1:0][COMP_W-1:0] src_comp;
  logic [COMP_W-1:0]               size_mask;
  int                              cs;

  assign px_b = src_px;

  always_comb begin
    cs = int'(size_m1) + 1;
    src_comp  = '0;
    size_mask = '0;
    for (int b = 0; b < COMP_BYTES; b++) begin
      if (b < cs) size_mask[b*8 +: 8] = 8'hff;
    end
    for (int k = 0; k < NUM_COMP; k++) begin
      for (int b = 0; b < COMP_BYTES; b++) begin
        if (b < cs) src_comp[k][b*8 +: 8] = px_b[IDX_W'(k*cs + b)];
      end
    end

    comp  = '0;
    write = 1'b1;
    err   = 1'b0;
    case (sel_e'(sel))
      SEL_SX, SEL_SY, SEL_SZ, SEL_SW: begin
        if (sel > {1'b0, src_m1}) err = 1'b1;
        else comp = src_comp[sel[1:0]];
      end
      SEL_KA:   comp  = ka & size_mask;
      SEL_KB:   comp  = kb & size_mask;
      SEL_SKIP: write = 1'b0;
      default:  err   = 1'b1;
    endcase
    if (!active) begin
      comp  = '0;
      write = 1'b0;
      err   = 1'b0;
    end
  end
endmodule

// File: rtl/remap_pack.sv
module remap_pack
  import remap_pkg::*;
#(
  parameter int COMP_BYTES = 4,
  parameter int NUM_COMP   = 4
) (
  input  logic [NUM_COMP-1:0][COMP_BYTES*8-1:0] comp,
  input  logic [NUM_COMP-1:0]                   write,
  input  logic [CNT_W-1:0]                      size_m1,
  output logic [COMP_BYTES*NUM_COMP*8-1:0]      px,
  output logic [COMP_BYTES*NUM_COMP-1:0]        be
);
  localparam int PIX_BYTES = COMP_BYTES * NUM_COMP;
  localparam int IDX_W     = $clog2(PIX_BYTES);

  logic [PIX_BYTES-1:0][7:0] px_b;
  int                        cs;

  always_comb begin
    cs   = int'(size_m1) + 1;
    px_b = '0;
    be   = '0;
    for (int j = 0; j < NUM_COMP; j++) begin
      for (int b = 0; b < COMP_BYTES; b++) begin
        if (b < cs) begin
          px_b[IDX_W'(j*cs + b)] = comp[j][b*8 +: 8];
          be[IDX_W'(j*cs + b)]   = write[j];
        end
      end
    end
  end

  assign px = px_b;
endmodule

// File: rtl/pixel_remap.sv
module pixel_remap
  import remap_pkg::*;
#(
  parameter int COMP_BYTES = 4,
  parameter int NUM_COMP   = 4,
  parameter int CTRL_W     = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [COMP_BYTES*8-1:0]            const_a,
  input  logic [COMP_BYTES*8-1:0]            const_b,
  input  logic [CTRL_W-1:0]                  remap_ctrl,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [COMP_BYTES*NUM_COMP*8-1:0]   in_pixel,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [COMP_BYTES*NUM_COMP*8-1:0]   out_pixel,
  output logic [COMP_BYTES*NUM_COMP-1:0]     out_be,
  output logic                               out_err
);
  localparam int COMP_W    = COMP_BYTES * 8;
  localparam int PIX_BYTES = COMP_BYTES * NUM_COMP;
  localparam int PIX_W     = PIX_BYTES * 8;

  remap_cfg_t                      cfg;
  logic [NUM_COMP-1:0][COMP_W-1:0] lane_comp;
  logic [NUM_COMP-1:0]             lane_wr;
  logic [NUM_COMP-1:0]             lane_err;
  logic [PIX_W-1:0]                px_d;
  logic [PIX_BYTES-1:0]            be_d;

  remap_cfg_decode #(.CTRL_W(CTRL_W), .NUM_COMP(NUM_COMP)) u_dec (
    .ctrl (remap_ctrl),
    .cfg  (cfg)
  );

  for (genvar j = 0; j < NUM_COMP; j++) begin : g_lane
    remap_lane #(.COMP_BYTES(COMP_BYTES), .NUM_COMP(NUM_COMP)) u_lane (
      .sel     (cfg.sel[j]),
      .size_m1 (cfg.size_m1),
      .src_m1  (cfg.src_m1),
      .active  (CNT_W'(j) <= cfg.dst_m1),
      .src_px  (in_pixel),
      .ka      (const_a),
      .kb      (const_b),
      .comp    (lane_comp[j]),
      .write   (lane_wr[j]),
      .err     (lane_err[j])
    );
  end

  remap_pack #(.COMP_BYTES(COMP_BYTES), .NUM_COMP(NUM_COMP)) u_pack (
    .comp    (lane_comp),
    .write   (lane_wr),
    .size_m1 (cfg.size_m1),
    .px      (px_d),
    .be      (be_d)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_pixel <= px_d;
      out_be    <= be_d;
      out_err   <= |lane_err;
    end
  end
endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
  parameter int COMP_BYTES = 4,
  parameter int NUM_COMP   = 4
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             in_valid,
  input logic                             in_ready,
  input logic                             out_valid,
  input logic                             out_ready,
  input logic [COMP_BYTES*NUM_COMP*8-1:0] out_pixel,
  input logic [COMP_BYTES*NUM_COMP-1:0]   out_be,
  input logic                             out_err
);
  localparam int PIX_BYTES = COMP_BYTES * NUM_COMP;

  logic [PIX_BYTES*8-1:0] be_bits;
  for (genvar i = 0; i < PIX_BYTES; i++) begin : g_exp
    assign be_bits[i*8 +: 8] = {8{out_be[i]}};
  end

  p_reset_empty_r9: assert property (@(posedge clk) rst |=> !out_valid);

  p_accept_shows_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_empty_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)
                                   && $stable(out_be) && $stable(out_err)));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_masked_zero_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_pixel & ~be_bits) == '0));
endmodule

bind pixel_remap remap_checker #(.COMP_BYTES(COMP_BYTES), .NUM_COMP(NUM_COMP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel),
  .out_be    (out_be),
  .out_err   (out_err)
);

// File: tb/tb_pixel_remap.sv
module tb_pixel_remap;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  const_a = 32'hA3A2A1A0;
  logic [31:0]  const_b = 32'hB3B2B1B0;
  logic [31:0]  remap_ctrl = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_pixel = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_pixel;
  logic [15:0]  out_be;
  logic         out_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [127:0] SRC = 128'h1f1e1d1c1b1a19181716151413121110;

  always #2.5 clk = ~clk;

  pixel_remap dut (
    .clk(clk), .rst(rst), .const_a(const_a), .const_b(const_b),
    .remap_ctrl(remap_ctrl), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_be(out_be), .out_err(out_err)
  );

  // control word per R10: sel X/Y/Z/W at [2:0],[6:4],[10:8],[14:12]; size-1 [17:16]; src-1 [21:20]; dst-1 [25:24]
  function automatic logic [31:0] mk(input logic [2:0] x, y, z, w,
                                     input logic [1:0] cs, sn, dn);
    logic [31:0] c;
    c = '0;
    c[2:0] = x; c[6:4] = y; c[10:8] = z; c[14:12] = w;
    c[17:16] = cs; c[21:20] = sn; c[25:24] = dn;
    return c;
  endfunction

  typedef struct packed {
    logic [31:0]  ctrl;
    logic [127:0] exp_px;
    logic [15:0]  exp_be;
    logic         exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{mk(0,1,2,3,3,3,3), SRC, 16'hffff, 1'b0},
    '{mk(3,2,1,0,0,3,3), 128'h10111213, 16'h000f, 1'b0},
    '{mk(4,5,1,0,1,1,2), 128'h1312B1B0A1A0, 16'h003f, 1'b0},
    '{mk(0,6,2,6,0,3,3), 128'h00120010, 16'h0005, 1'b0},
    '{mk(2,0,0,0,1,1,1), 128'h11100000, 16'h000f, 1'b1},
    '{mk(7,0,0,0,3,0,0), 128'h0, 16'h000f, 1'b1},
    '{mk(0,7,2,3,3,0,0), 128'h13121110, 16'h000f, 1'b0},
    '{mk(2,0,1,4,2,2,3), 128'hA2A1A0151413121110181716, 16'h0fff, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1 R10 identity";
      1: return "R1 R6 reverse bytes";
      2: return "R2 R5 constants";
      3: return "R3 no-write";
      4: return "R4 out-of-range source";
      5: return "R4 reserved code";
      6: return "R5 inactive lanes";
      default: return "R6 three-byte size";
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] c, input logic [127:0] px);
    @(negedge clk);
    remap_ctrl = c;
    in_pixel   = px;
    in_valid   = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 out_valid in reset", 128'(out_valid), 128'(0));
    check("R9 in_ready in reset", 128'(in_ready), 128'(1));
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ctrl, SRC);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      check({tag_of(i), " R7 valid"}, 128'(out_valid), 128'(1));
      check({tag_of(i), " data"}, out_pixel, VECS[i].exp_px);
      check({tag_of(i), " be"}, 128'(out_be), 128'(VECS[i].exp_be));
      check({tag_of(i), " err"}, 128'(out_err), 128'(VECS[i].exp_err));
      @(posedge clk);
      #1;
      check({tag_of(i), " R7 drained"}, 128'(out_valid), 128'(0));
    end

    // R8: back-pressure holds the output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0].ctrl, SRC);
    @(posedge clk);
    #1;
    check("R7 first accepted", 128'(out_valid), 128'(1));
    drive(VECS[1].ctrl, SRC);
    #1;
    check("R8 in_ready low when stalled", 128'(in_ready), 128'(0));
    @(posedge clk);
    #1;
    check("R8 held data", out_pixel, SRC);
    check("R8 held be", 128'(out_be), 128'(16'hffff));
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R7 second after drain", out_pixel, 128'h10111213);
    check("R7 second valid", 128'(out_valid), 128'(1));
    @(posedge clk);
    #1;
    check("R7 empty again", 128'(out_valid), 128'(0));

    // R9: reset empties a full register
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[2].ctrl, SRC);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R9 reset clears valid", 128'(out_valid), 128'(0));
    rst = 1'b0;
    out_ready = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule